// File: doc/BRIEF.md
# Up/Down Timer Counter Core

This block is the counting heart of a small timer. It holds an 8-bit count that changes only on a qualified tick. A 3-bit selector chooses one of seven tick strobes, and a selector value of zero gates every tick off so the count freezes. On each qualified tick, external controls decide what happens:

- the count clears to zero;
- the count steps by one, up or down, depending on a direction input;
- the count is left alone.

A processor port can load the count in any cycle, whether or not ticks are arriving, and the count is always visible on the read bus. When a load meets a tick in the same cycle, the load wins.

The block registers two condition outputs: one for a count at its maximum value and one for a count at zero. It also keeps an overflow flag. A 2-bit mode input chooses which counting event sets the flag. Software clears the flag by a write-one strobe, or by acknowledging the interrupt. The interrupt request is the flag gated by an enable bit, and it is registered alongside the flag.

Top module: `updn_timer_core`

## Requirements
- R1: While reset is high and on the first cycle after it, the count reads 0, the bottom output is 1, and the top output, the overflow flag and the interrupt are all 0.
- R2: On a qualified tick with the count request high and clear low, the count rises by one when the direction input is 1 and falls by one when it is 0. It wraps modulo 256 in both directions, and the new value appears one clock after the tick.
- R3: On a qualified tick with the clear input high, the count becomes 0 even when the count request is also high.
- R4: With the selector at 0, no tick strobe changes the count. With the selector at n (1 to 7), only strobe bit n-1 qualifies a tick, and the other strobe bits have no effect.
- R5: A processor load sets the count to the written data one clock later. This happens whether or not a tick is present, and it overrides a clear or a count request in the same cycle. A load cycle never sets the overflow flag. The read bus always shows the current count.
- R6: The top output is 1 exactly when the count is 255. The bottom output is 1 exactly when the count is 0. Both track the count with no extra delay.
- R7: In mode 0, the flag sets on a counting tick that wraps the count, either 255 to 0 going up or 0 to 255 going down.
- R8: In mode 1, the flag sets on a counting tick whose new count is 255. In mode 2, it sets on a counting tick whose new count is 0, and a clear does not set it. In mode 3, it never sets.
- R9: The flag clears on the software clear strobe or on the acknowledge pulse. If a set event happens in the same cycle, the set wins.
- R10: The interrupt output equals the flag ANDed with the enable bit, and it updates on the same clock as the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_src | input | 7 | Tick strobes; bit n-1 is chosen by selector value n |
| clk_sel | input | 3 | Tick selector; 0 stops the counter |
| cnt_req | input | 1 | Step the count on a qualified tick |
| cnt_up | input | 1 | Direction: 1 up, 0 down |
| cnt_clr | input | 1 | Clear the count on a qualified tick |
| ovf_mode | input | 2 | Flag mode: 0 wrap, 1 land on max, 2 land on zero, 3 off |
| cpu_cnt_we | input | 1 | Processor load strobe |
| cpu_cnt_wdata | input | 8 | Processor load data |
| cpu_flag_clr | input | 1 | Write-one clear of the overflow flag |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| cnt_rdata | output | 8 | Current count |
| cnt_top | output | 1 | Count equals 255 |
| cnt_bottom | output | 1 | Count equals 0 |
| ovf_flag | output | 1 | Overflow flag |
| ovf_irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check:
- the count freezes when no tick and no load occur;
- a load wins and lands one clock later;
- clear and step each land in the cycle after their tick;
- top and bottom are never both set;
- the interrupt never rises without the flag;
- the flag cannot rise while mode 3 is selected.

Some behaviour only the scenarios can show: which strobe a given selector value picks, the exact wrap points that set the flag in each mode, that a clear in mode 2 leaves the flag alone, and that a set beats a same-cycle clear.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;

  typedef enum logic [1:0] {
    OVF_WRAP      = 2'd0,
    OVF_AT_TOP    = 2'd1,
    OVF_AT_BOTTOM = 2'd2,
    OVF_OFF       = 2'd3
  } ovf_mode_e;

endpackage

// File: rtl/updn_tick_select.sv
module updn_tick_select #(
  parameter int NUM_SRC = 7,
  parameter int SEL_W   = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               tick_o
);

  logic [NUM_SRC-1:0] hit;

  // One decoded comparator per strobe; selector 0 matches none of them
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hit[i] = (sel_i == SEL_W'(i + 1)) && src_i[i];
  end

  assign tick_o = |hit;

endmodule

// File: rtl/updn_count_core.sv
module updn_count_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic         req_i,
  input  logic         up_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] count_q,
  output logic         top_q,
  output logic         bottom_q,
  output logic         evt_wrap_o,
  output logic         evt_land_top_o,
  output logic         evt_land_bot_o
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] nxt;
  logic         step;

  // Next-count selection: a load beats a clear, and a clear beats a step
  always_comb begin
    nxt  = count_q;
    step = 1'b0;
    if (wr_en_i) begin
      nxt = wr_data_i;
    end else if (tick_i && clr_i) begin
      nxt = '0;
    end else if (tick_i && req_i) begin
      step = 1'b1;
      nxt  = up_i ? count_q + ONE : count_q - ONE;
    end
  end

  assign evt_wrap_o     = step && (up_i ? (count_q == MAXV) : (count_q == '0));
  assign evt_land_top_o = step && (nxt == MAXV);
  assign evt_land_bot_o = step && (nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      top_q    <= 1'b0;
      bottom_q <= 1'b1;
    end else begin
      count_q  <= nxt;
      top_q    <= (nxt == MAXV);
      bottom_q <= (nxt == '0);
    end
  end

  p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !wr_en_i) |=> $stable(count_q));

  p_write_prio_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (count_q == $past(wr_data_i)));

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_i && clr_i && !wr_en_i) |=> (count_q == '0));

  p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_i && req_i && up_i && !clr_i && !wr_en_i)
      |=> (count_q == $past(count_q) + ONE));

  p_step_dn_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_i && req_i && !up_i && !clr_i && !wr_en_i)
      |=> (count_q == $past(count_q) - ONE));

  p_top_bottom_r6: assert property (@(posedge clk) disable iff (rst)
    top_q |-> !bottom_q);

endmodule

// File: rtl/updn_ovf_flag.sv
module updn_ovf_flag
  import updn_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  ovf_mode_e mode_i,
  input  logic      evt_wrap_i,
  input  logic      evt_land_top_i,
  input  logic      evt_land_bot_i,
  input  logic      sw_clr_i,
  input  logic      ack_i,
  input  logic      irq_en_i,
  output logic      flag_q,
  output logic      irq_q
);

  logic set_evt;
  logic flag_n;

  always_comb begin
    unique case (mode_i)
      OVF_WRAP:      set_evt = evt_wrap_i;
      OVF_AT_TOP:    set_evt = evt_land_top_i;
      OVF_AT_BOTTOM: set_evt = evt_land_bot_i;
      default:       set_evt = 1'b0;
    endcase
  end

  // A hardware set event wins over a same-cycle clear
  always_comb begin
    if (set_evt)                flag_n = 1'b1;
    else if (sw_clr_i || ack_i) flag_n = 1'b0;
    else                        flag_n = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_n;
      irq_q  <= flag_n && irq_en_i;
    end
  end

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> flag_q);

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    ((sw_clr_i || ack_i) && !set_evt) |=> !flag_q);

  p_mode_off_r8: assert property (@(posedge clk) disable iff (rst)
    ((mode_i == OVF_OFF) && !flag_q) |=> !flag_q);

endmodule

// File: rtl/updn_timer_core.sv
module updn_timer_core
  import updn_timer_pkg::*;
#(
  parameter int W       = 8,
  parameter int NUM_SRC = 7,
  parameter int SEL_W   = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] tick_src,
  input  logic [SEL_W-1:0]   clk_sel,
  input  logic               cnt_req,
  input  logic               cnt_up,
  input  logic               cnt_clr,
  input  logic [1:0]         ovf_mode,
  input  logic               cpu_cnt_we,
  input  logic [W-1:0]       cpu_cnt_wdata,
  input  logic               cpu_flag_clr,
  input  logic               irq_en,
  input  logic               irq_ack,
  output logic [W-1:0]       cnt_rdata,
  output logic               cnt_top,
  output logic               cnt_bottom,
  output logic               ovf_flag,
  output logic               ovf_irq
);

  logic tick;
  logic evt_wrap;
  logic evt_top;
  logic evt_bot;

  updn_tick_select #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
    .src_i  (tick_src),
    .sel_i  (clk_sel),
    .tick_o (tick)
  );

  updn_count_core #(.W(W)) u_cnt (
    .clk            (clk),
    .rst            (rst),
    .tick_i         (tick),
    .clr_i          (cnt_clr),
    .req_i          (cnt_req),
    .up_i           (cnt_up),
    .wr_en_i        (cpu_cnt_we),
    .wr_data_i      (cpu_cnt_wdata),
    .count_q        (cnt_rdata),
    .top_q          (cnt_top),
    .bottom_q       (cnt_bottom),
    .evt_wrap_o     (evt_wrap),
    .evt_land_top_o (evt_top),
    .evt_land_bot_o (evt_bot)
  );

  updn_ovf_flag u_flag (
    .clk            (clk),
    .rst            (rst),
    .mode_i         (ovf_mode_e'(ovf_mode)),
    .evt_wrap_i     (evt_wrap),
    .evt_land_top_i (evt_top),
    .evt_land_bot_i (evt_bot),
    .sw_clr_i       (cpu_flag_clr),
    .ack_i          (irq_ack),
    .irq_en_i       (irq_en),
    .flag_q         (ovf_flag),
    .irq_q          (ovf_irq)
  );

  p_sel_off_r4: assert property (@(posedge clk) disable iff (rst)
    ((clk_sel == '0) && !cpu_cnt_we) |=> $stable(cnt_rdata));

endmodule

// File: tb/sim_updn_timer_core.sv
module sim_updn_timer_core;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] tick_src = '0;
  logic [2:0] clk_sel = '0;
  logic       cnt_req = 1'b0;
  logic       cnt_up = 1'b1;
  logic       cnt_clr = 1'b0;
  logic [1:0] ovf_mode = 2'd0;
  logic       cpu_cnt_we = 1'b0;
  logic [7:0] cpu_cnt_wdata = '0;
  logic       cpu_flag_clr = 1'b0;
  logic       irq_en = 1'b0;
  logic       irq_ack = 1'b0;
  logic [7:0] cnt_rdata;
  logic       cnt_top, cnt_bottom, ovf_flag, ovf_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct packed {
    logic [7:0] cnt;
    logic       top;
    logic       bot;
    logic       flag;
    logic       irq;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  logic [7:0] m_cnt = '0;
  logic       m_flag = 1'b0;

  always #5 clk = ~clk;

  updn_timer_core u0 (
    .clk(clk), .rst(rst), .tick_src(tick_src), .clk_sel(clk_sel),
    .cnt_req(cnt_req), .cnt_up(cnt_up), .cnt_clr(cnt_clr),
    .ovf_mode(ovf_mode), .cpu_cnt_we(cpu_cnt_we),
    .cpu_cnt_wdata(cpu_cnt_wdata), .cpu_flag_clr(cpu_flag_clr),
    .irq_en(irq_en), .irq_ack(irq_ack), .cnt_rdata(cnt_rdata),
    .cnt_top(cnt_top), .cnt_bottom(cnt_bottom), .ovf_flag(ovf_flag),
    .ovf_irq(ovf_irq)
  );

  // Driver: model one clock from the requirements, queue the result, advance
  task automatic cyc(input string tag);
    logic       tk, step, set;
    logic [7:0] nc;
    logic       nf;
    exp_t       e;
    tk   = (clk_sel != 3'd0) && tick_src[clk_sel - 3'd1];
    step = 1'b0;
    nc   = m_cnt;
    if (cpu_cnt_we) nc = cpu_cnt_wdata;
    else if (tk && cnt_clr) nc = 8'd0;
    else if (tk && cnt_req) begin
      step = 1'b1;
      nc = cnt_up ? m_cnt + 8'd1 : m_cnt - 8'd1;
    end
    case (ovf_mode)
      2'd0:    set = step && (cnt_up ? (m_cnt == 8'hFF) : (m_cnt == 8'h00));
      2'd1:    set = step && (nc == 8'hFF);
      2'd2:    set = step && (nc == 8'h00);
      default: set = 1'b0;
    endcase
    nf = set ? 1'b1 : ((cpu_flag_clr || irq_ack) ? 1'b0 : m_flag);
    e.cnt = nc; e.top = (nc == 8'hFF); e.bot = (nc == 8'h00);
    e.flag = nf; e.irq = nf && irq_en;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    m_cnt  = nc;
    m_flag = nf;
    @(negedge clk);
    tick_src = '0; cnt_clr = 1'b0; cpu_cnt_we = 1'b0;
    cpu_flag_clr = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic load(input logic [7:0] v, input string tag);
    cpu_cnt_we = 1'b1; cpu_cnt_wdata = v;
    cyc(tag);
  endtask

  // Monitor: compare just after each edge
  always @(posedge clk) begin
    #1;
    if (!rst && exp_q.size() > 0) begin
      exp_t  e;
      exp_t  a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {cnt_rdata, cnt_top, cnt_bottom, ovf_flag, ovf_irq};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: cnt/top/bot/flag/irq actual %h/%b/%b/%b/%b expected %h/%b/%b/%b/%b",
                 t, a.cnt, a.top, a.bot, a.flag, a.irq,
                 e.cnt, e.top, e.bot, e.flag, e.irq);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values while held
    checks++;
    if ({cnt_rdata, cnt_top, cnt_bottom, ovf_flag, ovf_irq} !== {8'h00, 4'b0100}) begin
      errors++;
      $display("FAIL R1 reset actual %h %b%b%b%b expected 00 0100",
               cnt_rdata, cnt_top, cnt_bottom, ovf_flag, ovf_irq);
    end
    rst = 1'b0;
    cyc("R1 idle after reset");

    // R2 R6 R7: count up through the wrap with mode 0
    clk_sel = 3'd1; cnt_req = 1'b1; cnt_up = 1'b1; ovf_mode = 2'd0;
    load(8'hFD, "R5 load FD");
    tick_src = 7'b0000001; cyc("R2 up FE");
    tick_src = 7'b0000001; cyc("R6 up to top FF");
    tick_src = 7'b0000001; cyc("R7 up wrap sets flag");
    cpu_flag_clr = 1'b1; cyc("R9 sw clear");

    // R7 R10: down wrap with interrupt enabled
    irq_en = 1'b1; cnt_up = 1'b0;
    tick_src = 7'b0000001; cyc("R7 down wrap sets flag, R10 irq");
    tick_src = 7'b0000001; cyc("R2 down FE");
    irq_ack = 1'b1; cyc("R9 ack clears, R10 irq drops");

    // R4: selector gating
    clk_sel = 3'd0; tick_src = 7'h7F; cyc("R4 selector 0 frozen");
    clk_sel = 3'd3; tick_src = 7'b1111011; cyc("R4 other strobes ignored");
    tick_src = 7'b0000100; cyc("R4 strobe 2 counts");
    clk_sel = 3'd7; tick_src = 7'b1000000; cyc("R4 strobe 6 counts");

    // R3: clear wins over count
    cnt_clr = 1'b1; tick_src = 7'b1000000; cyc("R3 clear over count");
    cnt_clr = 1'b1; cyc("R3 clear without tick ignored");

    // R5: load overrides clear and tick, no flag
    load(8'h42, "R5 load while idle");
    cnt_up = 1'b1; cnt_clr = 1'b1; tick_src = 7'h40; load(8'hFF, "R5 load over clear");
    tick_src = 7'h40; load(8'h00, "R5 load over wrap, no flag");

    // R8: modes 1, 2, 3
    ovf_mode = 2'd1; load(8'hFE, "R8 load FE");
    tick_src = 7'h40; cyc("R8 mode1 land on max sets");
    cpu_flag_clr = 1'b1; cyc("R9 sw clear");
    ovf_mode = 2'd2; cnt_up = 1'b0; load(8'h01, "R8 load 01");
    tick_src = 7'h40; cyc("R8 mode2 land on zero sets");
    irq_ack = 1'b1; cyc("R9 ack clears");
    load(8'h05, "R8 load 05");
    cnt_clr = 1'b1; tick_src = 7'h40; cyc("R8 mode2 clear does not set");
    ovf_mode = 2'd3; tick_src = 7'h40; cyc("R8 mode3 wrap no flag");
    cnt_up = 1'b1; tick_src = 7'h40; cyc("R8 mode3 wrap up no flag");

    // R9: set beats same-cycle clear
    ovf_mode = 2'd0; load(8'hFF, "R9 load FF");
    tick_src = 7'h40; cpu_flag_clr = 1'b1; irq_ack = 1'b1; cyc("R9 set wins over clear");
    irq_en = 1'b0; cyc("R10 enable off drops irq");
    irq_ack = 1'b1; cyc("R9 ack clears");

    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule